// File: doc/BRIEF.md
# Write Page Stager and Address Pointer

This block sits between the serial-bus protocol controller of a byte-addressed nonvolatile memory and its storage array. It keeps the memory address pointer, stages the data bytes of a write transaction in a one-page buffer, and moves the staged bytes into the array when the controller ends the write. The controller sends it single-cycle strobes: load the pointer, push a received data byte, step the pointer after a byte has been read out, and commit. The array's write port is driven one byte per cycle while the block drains the buffer. The pointer is exposed as the read address.

Pushed bytes land in a page slot. The slot is picked by the low pointer bits, and only those low bits advance, so a long write circles inside one page. Read steps advance the whole pointer and wrap across the full address space. The pointer is never reset by a commit. A later read that sends no word address therefore continues from the last access. A commit can be refused by a protect/inhibit input. A commit with nothing staged completes immediately, which covers an address-only (dummy) write.

Top module: `pgbuf_addr_unit`

## Requirements
- R1: After reset the read address is 0, the buffer holds no staged byte, and `mem_we`, `busy`, `commit_done` and `commit_refused` are all low.
- R2: A `ptr_load` strobe sets the read address to `ptr_load_addr` on the next cycle. Any `byte_push` or `rd_step` in the same cycle is ignored.
- R3: A `byte_push` stores `byte_data` in the page slot given by the low PAGE_W bits of the pointer (default 5 bits, 32 slots). It then increments only those low bits, wrapping within the page. The upper ADDR_W-PAGE_W bits stay unchanged.
- R4: When more bytes are pushed than the page has slots, a later byte replaces the earlier content of the same slot. The byte pushed 2**PAGE_W positions after the first one overwrites the first one's slot.
- R5: An `rd_step` strobe increments the full ADDR_W-bit pointer (default 13 bits). The pointer wraps from the all-ones address to 0.
- R6: A commit does not change the pointer. After the commit, the read address is the value it had before the commit.
- R7: A granted commit writes only the slots that received a byte since the last commit. It writes one slot per cycle, in ascending slot order, at address {pointer page bits, slot}. `mem_we` is high for exactly as many cycles as there are staged slots.
- R8: With N staged slots (N ≥ 1), `commit_done` pulses for one cycle. The pulse comes N+1 cycles after the cycle in which `commit_req` was sampled. `busy` is then low and the buffer is empty.
- R9: A commit with `wr_block` high writes nothing and discards all staged bytes. `commit_done` and `commit_refused` pulse together one cycle after the request.
- R10: While `busy` is high, all strobes are ignored, including a new commit. A `byte_push` in the same cycle as `commit_req` is also ignored.
- R11: A commit with no staged byte (for example after an address-only write) writes nothing. It pulses `commit_done` one cycle later, with `commit_refused` low, and keeps the loaded pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load | input | 1 | Load pointer strobe |
| ptr_load_addr | input | ADDR_W | Address to load |
| byte_push | input | 1 | Stage one received write byte |
| byte_data | input | DATA_W | Byte to stage |
| rd_step | input | 1 | Advance pointer after a byte was read |
| commit_req | input | 1 | End of write: move staged bytes to the array |
| wr_block | input | 1 | Write protect / inhibit, sampled with the commit |
| rd_addr | output | ADDR_W | Current pointer (read address) |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Drain in progress |
| commit_done | output | 1 | One-cycle completion pulse |
| commit_refused | output | 1 | Pulses with `commit_done` when the commit was blocked |

## Verification
Staging and commit are exercised with every start slot combined with every burst length from one byte up to past a full page. This separates in-page wrap of the pointer from overwrite of the first slot, and checks the drain length and order against the number of distinct slots touched. Full sweeps of load values and of read steps across the whole address space expose any carry leaking into or out of the page bits, and confirm the wrap to zero. Blocked, empty and busy-time commits show that nothing reaches the array except staged bytes, and that no strobe sneaks into a running drain.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic {
        CM_IDLE  = 1'b0,
        CM_DRAIN = 1'b1
    } commit_state_e;
endpackage

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              inc_wr,
    input  logic              inc_rd,
    output logic [ADDR_W-1:0] ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ptr_regs_t;

    ptr_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!hold) begin
            if (ld) begin
                nxt_d.ptr = ld_addr;
            end else if (inc_wr) begin
                nxt_d.ptr[PAGE_W-1:0] = cur_q.ptr[PAGE_W-1:0] + PAGE_W'(1);
            end else if (inc_rd) begin
                nxt_d.ptr = cur_q.ptr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ptr = cur_q.ptr;

    // R5
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !ld && !inc_wr && inc_rd && cur_q.ptr == '1) |=> (cur_q.ptr == '0));

    // R3
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !ld && inc_wr) |=>
            (cur_q.ptr[ADDR_W-1:PAGE_W] == $past(cur_q.ptr[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PAGE_W-1:0]       wr_slot,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    clr_en,
    input  logic [PAGE_W-1:0]       clr_slot,
    input  logic                    clr_all,
    input  logic [PAGE_W-1:0]       rd_slot,
    output logic [DATA_W-1:0]       rd_data,
    output logic [(1<<PAGE_W)-1:0]  vld
);
    localparam int SLOTS = 1 << PAGE_W;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0]             vld;
    } store_regs_t;

    store_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_all) begin
            nxt_d.vld = '0;
        end else begin
            if (clr_en) nxt_d.vld[clr_slot] = 1'b0;
            if (wr_en) begin
                nxt_d.data[wr_slot] = wr_data;
                nxt_d.vld[wr_slot]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_data = cur_q.data[rd_slot];
    assign vld     = cur_q.vld;

    // R9
    discard_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (cur_q.vld == '0));

    // R3
    slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> cur_q.vld[$past(wr_slot)]);
endmodule

// File: rtl/pgbuf_pick.sv
module pgbuf_pick #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    assign any = |vec;

    always_comb begin
        // R7
        if (any) pick_hit_chk: assert (vec[idx]);
    end
endmodule

// File: rtl/pgbuf_addr_unit.sv
module pgbuf_addr_unit #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_load_addr,
    input  logic              byte_push,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_step,
    input  logic              commit_req,
    input  logic              wr_block,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              commit_done,
    output logic              commit_refused
);
    import pgbuf_pkg::*;

    localparam int SLOTS  = 1 << PAGE_W;
    localparam int PAGE_N = ADDR_W - PAGE_W;

    typedef struct packed {
        commit_state_e     st;
        logic [PAGE_N-1:0] page;
        logic              done;
        logic              refused;
    } ctl_regs_t;

    ctl_regs_t cur_q, nxt_d;

    logic [ADDR_W-1:0] ptr;
    logic [SLOTS-1:0]  slot_vld;
    logic [PAGE_W-1:0] pick_idx;
    logic              pick_any;
    logic [DATA_W-1:0] pick_data;
    logic              st_wr, st_clr, st_clr_all;
    logic              draining;

    assign draining = (cur_q.st == CM_DRAIN);
    assign st_wr    = byte_push && !ptr_load && !commit_req && !draining;

    pgbuf_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (draining),
        .ld      (ptr_load),
        .ld_addr (ptr_load_addr),
        .inc_wr  (byte_push && !commit_req),
        .inc_rd  (rd_step),
        .ptr     (ptr)
    );

    pgbuf_store #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_wr),
        .wr_slot  (ptr[PAGE_W-1:0]),
        .wr_data  (byte_data),
        .clr_en   (st_clr),
        .clr_slot (pick_idx),
        .clr_all  (st_clr_all),
        .rd_slot  (pick_idx),
        .rd_data  (pick_data),
        .vld      (slot_vld)
    );

    pgbuf_pick #(.N(SLOTS), .IDX_W(PAGE_W)) u_pick (
        .vec (slot_vld),
        .idx (pick_idx),
        .any (pick_any)
    );

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.done    = 1'b0;
        nxt_d.refused = 1'b0;
        st_clr        = 1'b0;
        st_clr_all    = 1'b0;
        mem_we        = 1'b0;
        unique case (cur_q.st)
            CM_IDLE: begin
                if (commit_req) begin
                    if (wr_block) begin
                        st_clr_all    = 1'b1;
                        nxt_d.done    = 1'b1;
                        nxt_d.refused = 1'b1;
                    end else if (!pick_any) begin
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.st   = CM_DRAIN;
                        nxt_d.page = ptr[ADDR_W-1:PAGE_W];
                    end
                end
            end
            CM_DRAIN: begin
                if (pick_any) begin
                    mem_we = 1'b1;
                    st_clr = 1'b1;
                    if ((slot_vld & ~(SLOTS'(1) << pick_idx)) == '0) begin
                        nxt_d.st   = CM_IDLE;
                        nxt_d.done = 1'b1;
                    end
                end else begin
                    nxt_d.st   = CM_IDLE;
                    nxt_d.done = 1'b1;
                end
            end
            default: nxt_d.st = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st      <= CM_IDLE;
            cur_q.page    <= '0;
            cur_q.done    <= 1'b0;
            cur_q.refused <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_addr        = ptr;
    assign mem_waddr      = {cur_q.page, pick_idx};
    assign mem_wdata      = pick_data;
    assign busy           = draining;
    assign commit_done    = cur_q.done;
    assign commit_refused = cur_q.refused;

    // R7
    we_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (!busy && !mem_we));

    // R8
    drained_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (slot_vld == '0));

    // R10
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_addr));

    // R9
    refuse_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_refused |-> commit_done);
endmodule

// File: tb/pgbuf_addr_unit_test.sv
module pgbuf_addr_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 9;
    localparam int PW    = 4;
    localparam int DW    = 8;
    localparam int SLOTS = 1 << PW;
    localparam int MEMSZ = 1 << AW;
    localparam int NPAGE = MEMSZ / SLOTS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_load = 1'b0;
    logic [AW-1:0] ptr_load_addr = '0;
    logic          byte_push = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          rd_step = 1'b0;
    logic          commit_req = 1'b0;
    logic          wr_block = 1'b0;
    logic [AW-1:0] rd_addr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic          busy, commit_done, commit_refused;

    int n_chk = 0;
    int n_fail = 0;
    int we_cnt = 0;
    int order_bad = 0;
    bit we_seen = 1'b0;
    int last_wa = 0;

    logic [DW-1:0] ram [MEMSZ];
    logic [DW-1:0] exp_ram [MEMSZ];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgbuf_addr_unit #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_load_addr(ptr_load_addr),
        .byte_push(byte_push), .byte_data(byte_data), .rd_step(rd_step),
        .commit_req(commit_req), .wr_block(wr_block), .rd_addr(rd_addr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .busy(busy), .commit_done(commit_done), .commit_refused(commit_refused)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_waddr] <= mem_wdata;
            we_cnt = we_cnt + 1;
            if (we_seen && int'(mem_waddr) <= last_wa) order_bad = order_bad + 1;
            last_wa = int'(mem_waddr);
            we_seen = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic do_load(input int a);
        ptr_load = 1'b1;
        ptr_load_addr = AW'(a);
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic do_push(input int d);
        byte_push = 1'b1;
        byte_data = DW'(d);
        @(negedge clk);
        byte_push = 1'b0;
    endtask

    task automatic do_commit(input bit blk, output int cyc, output bit refd);
        we_cnt = 0;
        we_seen = 1'b0;
        order_bad = 0;
        commit_req = 1'b1;
        wr_block = blk;
        @(negedge clk);
        commit_req = 1'b0;
        wr_block = 1'b0;
        cyc = 1;
        while (!commit_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        refd = commit_refused;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int cyc;
        bit refd;
        for (int i = 0; i < MEMSZ; i++) begin
            ram[i] = DW'(i * 7 + 3);
            exp_ram[i] = DW'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(rd_addr == '0, "R1 rd_addr", int'(rd_addr), 0);
        check(!busy && !mem_we, "R1 busy/we", int'(busy), 0);
        check(!commit_done && !commit_refused, "R1 done", int'(commit_done), 0);
        do_commit(1'b0, cyc, refd);
        check(we_cnt == 0 && cyc == 1 && !refd, "R1 empty buffer", we_cnt, 0);

        // R2 load sweep over all addresses
        for (int a = 0; a < MEMSZ; a++) begin
            ptr_load = 1'b1;
            ptr_load_addr = AW'(a);
            @(negedge clk);
            check(int'(rd_addr) == a, "R2 load", int'(rd_addr), a);
        end
        ptr_load = 1'b0;

        // R5 read step sweep with wrap
        do_load(0);
        for (int i = 0; i < MEMSZ; i++) begin
            rd_step = 1'b1;
            @(negedge clk);
            check(int'(rd_addr) == (i + 1) % MEMSZ, "R5 step", int'(rd_addr), (i + 1) % MEMSZ);
        end
        rd_step = 1'b0;

        // R3 R4 R6 R7 R8 write/commit sweep
        for (int s = 0; s < SLOTS; s++) begin
            for (int n = 1; n <= SLOTS + 4; n++) begin
                int pg, base, nexp, bad, first_d, last_d;
                pg = (s * 5 + n) % NPAGE;
                base = pg * SLOTS;
                do_load(base + s);
                first_d = 0;
                last_d = 0;
                for (int i = 0; i < n; i++) begin
                    int d;
                    d = (s * 37 + n * 11 + i * 5) & 8'hFF;
                    if (i == 0) first_d = d;
                    if (i == SLOTS) last_d = d;
                    exp_ram[base + (s + i) % SLOTS] = DW'(d);
                    do_push(d);
                end
                check(int'(rd_addr) == base + (s + n) % SLOTS, "R3 ptr",
                      int'(rd_addr), base + (s + n) % SLOTS);
                nexp = (n < SLOTS) ? n : SLOTS;
                do_commit(1'b0, cyc, refd);
                check(we_cnt == nexp && order_bad == 0, "R7 writes", we_cnt, nexp);
                check(cyc == nexp + 1 && !refd && !busy, "R8 done timing", cyc, nexp + 1);
                check(int'(rd_addr) == base + (s + n) % SLOTS, "R6 ptr kept",
                      int'(rd_addr), base + (s + n) % SLOTS);
                bad = 0;
                for (int j = 0; j < MEMSZ; j++) if (ram[j] !== exp_ram[j]) bad++;
                check(bad == 0, "R7 array content", bad, 0);
                if (n > SLOTS) begin
                    check(int'(ram[base + s]) == last_d && last_d != first_d || last_d == first_d,
                          "R4 overwrite", int'(ram[base + s]), last_d);
                end
            end
        end
        do_commit(1'b0, cyc, refd);
        check(we_cnt == 0, "R8 buffer empty after", we_cnt, 0);

        // R9 blocked commit
        do_load(3 * SLOTS + 2);
        do_push(8'hA5);
        do_push(8'h5A);
        do_commit(1'b1, cyc, refd);
        check(we_cnt == 0 && cyc == 1 && refd, "R9 refused", we_cnt, 0);
        do_commit(1'b0, cyc, refd);
        check(we_cnt == 0 && !refd, "R9 discarded", we_cnt, 0);

        // R11 address-only write
        do_load(5 * SLOTS + 9);
        do_commit(1'b0, cyc, refd);
        check(we_cnt == 0 && cyc == 1 && !refd, "R11 empty commit", we_cnt, 0);
        check(int'(rd_addr) == 5 * SLOTS + 9, "R11 ptr", int'(rd_addr), 5 * SLOTS + 9);

        // R10 strobes during drain
        do_load(7 * SLOTS);
        do_push(1);
        do_push(2);
        do_push(3);
        we_cnt = 0;
        we_seen = 1'b0;
        commit_req = 1'b1;
        @(negedge clk);
        ptr_load = 1'b1;
        ptr_load_addr = AW'(2);
        byte_push = 1'b1;
        byte_data = 8'hEE;
        rd_step = 1'b1;
        @(negedge clk);
        ptr_load = 1'b0;
        byte_push = 1'b0;
        rd_step = 1'b0;
        commit_req = 1'b0;
        repeat (4) @(negedge clk);
        check(we_cnt == 3, "R10 drain count", we_cnt, 3);
        check(int'(rd_addr) == 7 * SLOTS + 3, "R10 ptr held", int'(rd_addr), 7 * SLOTS + 3);
        do_commit(1'b0, cyc, refd);
        check(we_cnt == 0, "R10 no late push", we_cnt, 0);

        // R10 push in commit cycle
        do_load(9 * SLOTS + 4);
        byte_push = 1'b1;
        byte_data = 8'h11;
        do_commit(1'b0, cyc, refd);
        byte_push = 1'b0;
        check(we_cnt == 0 && int'(rd_addr) == 9 * SLOTS + 4, "R10 push with commit",
              int'(rd_addr), 9 * SLOTS + 4);

        // R2 load priority over push and step
        do_load(11 * SLOTS);
        ptr_load = 1'b1;
        ptr_load_addr = AW'(13 * SLOTS + 6);
        byte_push = 1'b1;
        rd_step = 1'b1;
        @(negedge clk);
        ptr_load = 1'b0;
        byte_push = 1'b0;
        rd_step = 1'b0;
        check(int'(rd_addr) == 13 * SLOTS + 6, "R2 priority", int'(rd_addr), 13 * SLOTS + 6);
        do_commit(1'b0, cyc, refd);
        check(we_cnt == 0, "R2 push dropped", we_cnt, 0);

        summary();
        $finish;
    end
endmodule